// File: doc/BRIEF.md
# Hash Target Comparator with Leading-Zero Prefilter

This block judges whether a 256-bit hash value is numerically smaller than a 256-bit expanded difficulty target. Each hash arrives with a valid strobe. The block first applies a cheap screen: a configurable number of the hash's most significant bytes must all be zero. A hash that fails this screen is rejected whatever the full compare would say. A hash that passes is decided by a full unsigned magnitude compare against the target.

The result is registered. One cycle after a valid hash is sampled, exactly one of two strobes pulses: `solutionOut` when the hash is a solution, or `rejectOut` when it is not. Byte-order conversion and expansion of the target from a compact encoding take place outside the block. The required zero-byte count comes from a register. The expanded target always begins with at least four zero bytes, so any count below four is raised to four.

Top module: `hash_target_cmp`

## Requirements
- R1: While `rstN` is low, and in the first cycle after a clock edge at which `rstN` was low, both `solutionOut` and `rejectOut` are 0, even if `hashValid` is high.
- R2: When `hashValid` is high at a clock edge, exactly one of `solutionOut` or `rejectOut` is high for the following cycle. When `hashValid` is low at that edge, both are low.
- R3: Both values are unsigned with bit 255 as the most significant bit. Byte k (k = 0 is the first byte) is bits [255-8k -: 8]. A hash whose required leading bytes are all zero is a solution exactly when its value is strictly below `targetIn`. Otherwise it is rejected.
- R4: A hash equal to the target is rejected.
- R5: If any of the first N bytes of the hash is nonzero, the hash is rejected, even when it is numerically below the target. N is the effective zero-byte count.
- R6: The effective count N is `zeroBytesReq` raised to at least 4. A value of 0 to 3 therefore behaves as 4. A solution always has its first four bytes equal to zero.
- R7: With `zeroBytesReq` = 31, only byte 31 (bits [7:0]) of a solution may be nonzero.
- R8: The block accepts a hash on every clock cycle. Each hash in a back-to-back stream is judged on its own inputs.
- R9: Byte N itself is not screened. With count N, a hash whose first nonzero byte is byte N can still be a solution.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hashValid | input | 1 | Hash and target are valid this cycle |
| hashIn | input | 256 | Hash value, bit 255 most significant |
| targetIn | input | 256 | Expanded difficulty target |
| zeroBytesReq | input | 5 | Required leading zero bytes (effective 4..31) |
| solutionOut | output | 1 | Hash judged below target, one cycle after valid |
| rejectOut | output | 1 | Hash judged not a solution, one cycle after valid |

## Verification
The assertions check on every cycle that outputs stay quiet during reset and when no hash arrives, and that each valid hash yields exactly one outcome one cycle later. They also check that every solution was strictly below the target and had its first four bytes zero. Only the bench's scenarios show the interplay of the screen with the compare. These cases are a hash below the target but stopped by the screen, the exact boundary at byte N, the raising of counts below four, the count of 31, and hashes equal to the target. The bench covers them with directed vectors and with a stream of shaped random hashes whose leading bytes cluster near the target.

// File: rtl/hash_cmp_pkg.sv
package hash_cmp_pkg;

  // Strobes passed from the control to the datapath.
  typedef struct packed {
    logic evalEn;  // a valid hash is judged at this edge
    logic idleEn;  // no hash present: outputs return low
  } cmp_strobe_t;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/hash_cmp_ctrl.sv
module hash_cmp_ctrl
  import hash_cmp_pkg::*;
#(
  parameter int NUM_BYTES = 32,
  parameter int CNT_W     = 5,
  parameter int MIN_ZERO  = 4
) (
  input  logic             hashValid,
  input  logic [CNT_W-1:0] zeroBytesReq,
  output cmp_strobe_t      strobe,
  output logic [CNT_W-1:0] zeroReqEff
);

  localparam int MAX_ZERO = NUM_BYTES - 1;
  localparam logic [CNT_W-1:0] MinCnt = CNT_W'(MIN_ZERO);
  localparam logic [CNT_W-1:0] MaxCnt = CNT_W'(MAX_ZERO);

  always_comb begin
    strobe.evalEn = hashValid;
    strobe.idleEn = !hashValid;
  end

  // Keep the screen inside the range the target format allows.
  always_comb begin
    if (zeroBytesReq < MinCnt)      zeroReqEff = MinCnt;
    else if (zeroBytesReq > MaxCnt) zeroReqEff = MaxCnt;
    else                            zeroReqEff = zeroBytesReq;
  end

endmodule

// File: rtl/hash_cmp_datapath.sv
module hash_cmp_datapath
  import hash_cmp_pkg::*;
#(
  parameter int HASH_W = 256,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmp_strobe_t       strobe,
  input  logic [CNT_W-1:0]  zeroReqEff,
  input  logic [HASH_W-1:0] hashIn,
  input  logic [HASH_W-1:0] targetIn,
  output logic              solutionOut,
  output logic              rejectOut
);

  localparam int NUM_BYTES = HASH_W / BYTE_W;
  localparam int NUM_WORDS = HASH_W / WORD_W;

  logic [NUM_BYTES-1:0] byteZero;
  logic [NUM_BYTES-1:0] byteNeedZero;
  logic [NUM_WORDS-1:0] wordLt;
  logic [NUM_WORDS-1:0] wordEq;
  logic prefixOk;
  logic hashBelow;
  logic isSolution;
  logic solutionQ;
  logic rejectQ;

  // Leading-zero screen: index 0 is the most significant byte.
  for (genvar gB = 0; gB < NUM_BYTES; gB++) begin : g_byte
    assign byteZero[gB]     = (hashIn[HASH_W-1-BYTE_W*gB -: BYTE_W] == '0);
    assign byteNeedZero[gB] = (CNT_W'(gB) < zeroReqEff);
  end

  assign prefixOk = &(byteZero | ~byteNeedZero);

  // Magnitude compare split into words, resolved from the top word down.
  for (genvar gW = 0; gW < NUM_WORDS; gW++) begin : g_word
    logic [WORD_W-1:0] hWord;
    logic [WORD_W-1:0] tWord;
    assign hWord      = hashIn[HASH_W-1-WORD_W*gW -: WORD_W];
    assign tWord      = targetIn[HASH_W-1-WORD_W*gW -: WORD_W];
    assign wordLt[gW] = (hWord < tWord);
    assign wordEq[gW] = (hWord == tWord);
  end

  always_comb begin
    logic decided;
    decided   = 1'b0;
    hashBelow = 1'b0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (!decided && !wordEq[w]) begin
        hashBelow = wordLt[w];
        decided   = 1'b1;
      end
    end
  end

  assign isSolution = prefixOk && hashBelow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      solutionQ <= 1'b0;
      rejectQ   <= 1'b0;
    end else if (strobe.idleEn) begin
      solutionQ <= 1'b0;
      rejectQ   <= 1'b0;
    end else if (strobe.evalEn) begin
      solutionQ <= isSolution;
      rejectQ   <= !isSolution;
    end
  end

  assign solutionOut = solutionQ;
  assign rejectOut   = rejectQ;

endmodule

// File: rtl/hash_target_cmp.sv
module hash_target_cmp
  import hash_cmp_pkg::*;
#(
  parameter int HASH_W   = 256,
  parameter int WORD_W   = 32,
  parameter int CNT_W    = 5,
  parameter int MIN_ZERO = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hashValid,
  input  logic [HASH_W-1:0] hashIn,
  input  logic [HASH_W-1:0] targetIn,
  input  logic [CNT_W-1:0]  zeroBytesReq,
  output logic              solutionOut,
  output logic              rejectOut
);

  localparam int NUM_BYTES = HASH_W / BYTE_W;

  cmp_strobe_t      strobe;
  logic [CNT_W-1:0] zeroReqEff;

  hash_cmp_ctrl #(
    .NUM_BYTES(NUM_BYTES),
    .CNT_W    (CNT_W),
    .MIN_ZERO (MIN_ZERO)
  ) u_ctrl (
    .hashValid   (hashValid),
    .zeroBytesReq(zeroBytesReq),
    .strobe      (strobe),
    .zeroReqEff  (zeroReqEff)
  );

  hash_cmp_datapath #(
    .HASH_W(HASH_W),
    .WORD_W(WORD_W),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .zeroReqEff (zeroReqEff),
    .hashIn     (hashIn),
    .targetIn   (targetIn),
    .solutionOut(solutionOut),
    .rejectOut  (rejectOut)
  );

endmodule

// File: rtl/hash_target_cmp_chk.sv
module hash_target_cmp_chk #(
  parameter int HASH_W = 256,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              hashValid,
  input logic [HASH_W-1:0] hashIn,
  input logic [HASH_W-1:0] targetIn,
  input logic [CNT_W-1:0]  zeroBytesReq,
  input logic              solutionOut,
  input logic              rejectOut
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!solutionOut && !rejectOut)); // R1

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    hashValid |=> ($countones({solutionOut, rejectOut}) == 1)); // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !hashValid |=> (!solutionOut && !rejectOut)); // R2

  AST_SOL_BELOW: assert property (@(posedge clk) disable iff (!rstN)
    solutionOut |-> ($past(hashIn) < $past(targetIn))); // R3 R4

  AST_SOL_PREFIX: assert property (@(posedge clk) disable iff (!rstN)
    solutionOut |-> ($past(hashIn[HASH_W-1 -: 32]) == 32'd0)); // R6

  AST_SOL_FULLSCREEN: assert property (@(posedge clk) disable iff (!rstN)
    (solutionOut && ($past(zeroBytesReq) == CNT_W'(31)))
      |-> ($past(hashIn[HASH_W-1:8]) == '0)); // R7

endmodule

bind hash_target_cmp hash_target_cmp_chk #(
  .HASH_W(HASH_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .hashValid   (hashValid),
  .hashIn      (hashIn),
  .targetIn    (targetIn),
  .zeroBytesReq(zeroBytesReq),
  .solutionOut (solutionOut),
  .rejectOut   (rejectOut)
);

// File: tb/tb_hash_target_cmp.sv
module tb_hash_target_cmp;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         hashValid = 1'b0;
  logic [255:0] hashIn = '0;
  logic [255:0] targetIn = '0;
  logic [4:0]   zeroBytesReq = 5'd4;
  logic         solutionOut;
  logic         rejectOut;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // Expected outputs for the cycle after the most recently applied inputs.
  bit    expSol = 1'b0;
  bit    expRej = 1'b0;
  string expTag = "R1";

  always #2.5 clk = ~clk;

  hash_target_cmp dut (
    .clk         (clk),
    .rstN        (rstN),
    .hashValid   (hashValid),
    .hashIn      (hashIn),
    .targetIn    (targetIn),
    .zeroBytesReq(zeroBytesReq),
    .solutionOut (solutionOut),
    .rejectOut   (rejectOut)
  );

  function automatic bit refSolution(logic [255:0] h, logic [255:0] t, int req);
    int eff;
    eff = (req < 4) ? 4 : req;
    for (int i = 0; i < eff; i++)
      if (h[255-8*i -: 8] != 8'h00) return 1'b0;
    return (h < t);
  endfunction

  // Build a value with `zeros` leading zero bytes, then `lead`, then fill.
  function automatic logic [255:0] shape(int zeros, logic [7:0] lead, logic [255:0] fill);
    logic [255:0] v;
    v = fill;
    for (int i = 0; i < 32; i++) begin
      if (i < zeros) v[255-8*i -: 8] = 8'h00;
      else if (i == zeros) v[255-8*i -: 8] = lead;
    end
    return v;
  endfunction

  task automatic step(input bit rstVal, input bit v, input logic [255:0] h,
                      input logic [255:0] t, input int req, input string tag);
    @(negedge clk);
    vectors++;
    if (solutionOut !== expSol || rejectOut !== expRej) begin
      miscompares++;
      $display("FAIL %s: sol/rej actual %b/%b expected %b/%b at %0t",
               expTag, solutionOut, rejectOut, expSol, expRej, $time);
    end
    rstN         = rstVal;
    hashValid    = v;
    hashIn       = h;
    targetIn     = t;
    zeroBytesReq = req[4:0];
    if (!rstVal || !v) begin
      expSol = 1'b0;
      expRej = 1'b0;
    end else begin
      expSol = refSolution(h, t, req);
      expRej = !expSol;
    end
    expTag = tag;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [255:0] tgt;
    logic [255:0] h;

    // R1: valid hashes held during reset produce nothing.
    step(1'b0, 1'b1, '0, '1, 13, "R1");
    step(1'b0, 1'b1, '0, '1, 13, "R1");
    step(1'b1, 1'b0, '0, '1, 13, "R2");

    // R3: 13-byte screen, hash just below and just above the target.
    tgt = shape(13, 8'h40, {8{32'h0}});
    step(1'b1, 1'b1, shape(13, 8'h3f, '1), tgt, 13, "R3");
    step(1'b1, 1'b1, shape(13, 8'h41, '0), tgt, 13, "R3");
    // R4: equal to the target.
    step(1'b1, 1'b1, tgt, tgt, 13, "R4");
    step(1'b1, 1'b1, tgt - 256'd1, tgt, 13, "R4");

    // R5: below a loose target but fails the 13-byte screen.
    tgt = shape(4, 8'hff, '1);
    h   = shape(12, 8'h01, '0);
    step(1'b1, 1'b1, h, tgt, 13, "R5");
    // R9: same hash with the screen at 12 bytes passes.
    step(1'b1, 1'b1, h, tgt, 12, "R9");
    step(1'b1, 1'b1, shape(4, 8'h01, '0), tgt, 4, "R9");

    // R6: counts below four behave as four.
    tgt = shape(2, 8'h01, '0);
    h   = shape(3, 8'h05, '0);
    step(1'b1, 1'b1, h, tgt, 0, "R6");
    step(1'b1, 1'b1, h, tgt, 3, "R6");
    step(1'b1, 1'b1, shape(4, 8'h02, '0), tgt, 1, "R6");

    // R7: full screen of 31 bytes.
    tgt = 256'h10;
    step(1'b1, 1'b1, 256'h05, tgt, 31, "R7");
    step(1'b1, 1'b1, 256'h0105, 256'h1000, 31, "R7");
    step(1'b1, 1'b1, 256'h0f, tgt, 31, "R7");

    // R2: idle cycles in between.
    step(1'b1, 1'b0, 256'h05, tgt, 31, "R2");
    step(1'b1, 1'b0, '0, '1, 4, "R2");

    // R8: back-to-back stream of shaped random hashes.
    for (int k = 0; k < 400; k++) begin
      int tz;
      int hz;
      int rq;
      logic [7:0] tl;
      logic [7:0] hl;
      logic [255:0] fillA;
      logic [255:0] fillB;
      tz = $urandom_range(4, 20);
      hz = tz + $urandom_range(0, 2) - 1;
      rq = $urandom_range(0, 31);
      tl = 8'($urandom_range(1, 8));
      hl = 8'($urandom_range(0, 8));
      for (int j = 0; j < 8; j++) begin
        fillA[32*j +: 32] = $urandom;
        fillB[32*j +: 32] = $urandom;
      end
      tgt = shape(tz, tl, fillA);
      h   = (k % 17 == 0) ? tgt : shape(hz, hl, fillB);
      step(1'b1, ($urandom_range(0, 7) != 0), h, tgt, rq, "R8");
    end

    // Mid-stream reset.
    step(1'b0, 1'b1, '0, '1, 8, "R1");
    step(1'b1, 1'b1, '0, '1, 8, "R1");
    step(1'b1, 1'b0, '0, '1, 8, "R2");
    step(1'b1, 1'b0, '0, '1, 8, "R2");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule